// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the part of an SMBus slave that lets a device with a raised interrupt identify itself. The host sends a receive-byte transaction to the shared alert response address. Every device with a pending alert acknowledges that address and then returns its own 7-bit address. Responders settle contention through wired-AND arbitration, one bit at a time. A responder that sends the whole byte without losing arbitration emits a one-cycle pulse. The alarm logic next to it uses that pulse as a request to clear its latched alert. The alarm logic keeps the alert latched if the fault is still present.

The bus lines come in as raw sampled levels and are synchronised inside the block. The block drives SDA only through an output enable: when the enable is high, the open-drain pad pulls SDA low. The block never drives SCL. It does not decode general register access, stretch the clock or generate bus timing.

Top module: `smb_alert_responder`

## Requirements
- R1: The responder acknowledges only the address byte 0x19, which is address 0001100 followed by R/W = 1 (read). For any other address byte, including 0x18 (the write form), SDA stays released for the whole transaction.
- R2: The acknowledge is given only if `alert_pending_i` is high at the eighth SCL rising edge of the address byte. If it is low, SDA stays released, so the master reads the byte as 0xFF.
- R3: The returned byte is `{dev_addr_i, 1'b0}`, sent MSB first. Each bit is placed on SDA after the SCL falling edge that starts its bit slot.
- R4: At each SCL rising edge of the data byte, the responder samples SDA. If it reads low while its own output is released (sending a 1), it has lost arbitration. It then releases SDA until the next START or STOP. When two responders compete, the one with the lower address code completes its byte.
- R5: `alert_clear_o` pulses high for exactly one clock cycle, once per transaction. It pulses only when all eight data bits were sent without losing arbitration. The pulse follows the eighth data-bit SCL rising edge.
- R6: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) aborts any transfer in progress and releases SDA. A START, including a repeated START, begins the reception of a new address byte. After reset, SDA is released and no clear pulse is issued.
- R7: SCL and SDA pass through two synchroniser flops before edge detection. A change of `sda_oe_o` therefore appears at the third rising clock edge after the SCL falling edge that causes it.
- R8: The master's ACK or NACK after the data byte has no effect. The responder releases SDA at the SCL falling edge that ends the eighth data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_i | input | 1 | Sampled SDA line level (asynchronous) |
| sda_oe_o | output | 1 | High pulls SDA low through the open-drain pad |
| alert_pending_i | input | 1 | The device has a latched, unserviced alert |
| dev_addr_i | input | 7 | This device's own 7-bit bus address |
| alert_clear_o | output | 1 | One-cycle pulse after a won alert response |

## Verification
Every SCL edge reaches the state machine two cycles late, through the synchronisers, and the registered output adds a third cycle. A new SDA drive level is therefore due at the third clock edge after an SCL fall, and the clear pulse at the third edge after the eighth data-bit rise. One directed test pins that three-cycle latency: it checks that the enable is still low after two edges and high after the third. All other checks sample the wired-AND line at least ten cycles into each SCL high phase, and count clear pulses over the whole transaction, so they never depend on an exact edge. A bench model of a competing responder supplies the other side of the arbitration.

// File: rtl/smb_ara_pkg.sv
// Package: shared types for the alert response responder.
// Assumes: nothing; holds only the state encoding.
package smb_ara_pkg;

    typedef enum logic [2:0] {
        RSP_IDLE,     // bus free, nothing in progress
        RSP_ADDR,     // shifting in the address byte
        RSP_ACK_DRV,  // address matched, drive ACK at next SCL fall
        RSP_ACK_BIT,  // ACK driven, waiting for its SCL rise
        RSP_ACK_END,  // ACK clocked, first data bit goes out at SCL fall
        RSP_DATA,     // sending own address with arbitration
        RSP_MACK,     // byte sent, release SDA for the master's ACK slot
        RSP_IGNORE    // not addressed or lost: silent until START/STOP
    } rsp_state_t;

endpackage

// File: rtl/smb_ara_sync.sv
// Module: multi-line synchroniser with edge detection.
// Each asynchronous input passes through STAGES flops, then one more flop
// holds the previous synchronised level for rise/fall detection.
// Assumes: STAGES >= 2; lines idle high (open-drain bus), so reset loads 1.
module smb_ara_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the raw level through the synchroniser and keep the prior value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[g]};
                last  <= chain[STAGES-1];
            end
        end

        // Present the level and its edges.
        always_comb begin
            sync_o[g] = chain[STAGES-1];
            rise_o[g] = chain[STAGES-1] & ~last;
            fall_o[g] = ~chain[STAGES-1] & last;
        end
    end

endmodule

// File: rtl/smb_ara_cond.sv
// Module: bus condition detector.
// Flags START (SDA falls while SCL high) and STOP (SDA rises while SCL high)
// from synchronised lines.
// Assumes: SCL and SDA went through equal synchroniser depth.
module smb_ara_cond (
    input  logic scl_s,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);

    // Qualify SDA transitions with a high clock line.
    always_comb begin
        start_o = scl_s & sda_fall;
        stop_o  = scl_s & sda_rise;
    end

endmodule

// File: rtl/smb_ara_fsm.sv
// Module: alert response transaction engine.
// Receives the address byte, acknowledges the alert response address when an
// alert is pending, returns {own address, 0} MSB first with bitwise
// arbitration, and pulses clear_o when the whole byte went out unopposed.
// Assumes: one-cycle scl_rise/scl_fall/start/stop strobes from synchronised
// lines; sda_s sampled with the same latency as the SCL strobes.
module smb_ara_fsm
    import smb_ara_pkg::*;
#(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              pending_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic              sda_oe_o,
    output logic              clear_o
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] MATCH   = {ARA_ADDR, 1'b1};

    rsp_state_t        state;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              oe_q;
    logic              clr_q;
    logic [BYTE_W-1:0] rx_next;
    logic              tx_msb;

    // Next receive value and the bit currently being sent.
    always_comb begin
        rx_next = {rx_q[BYTE_W-2:0], sda_s};
        tx_msb  = tx_q[BYTE_W-1];
    end

    // Transaction sequencing, SDA drive and clear pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RSP_IDLE;
            rx_q  <= '0;
            tx_q  <= '0;
            cnt_q <= '0;
            oe_q  <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (start_i) begin
                state <= RSP_ADDR;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (stop_i) begin
                state <= RSP_IDLE;
                oe_q  <= 1'b0;
            end else begin
                unique case (state)
                    RSP_ADDR: begin
                        if (scl_rise) begin
                            rx_q <= rx_next;
                            if (cnt_q == LAST_BIT) begin
                                cnt_q <= '0;
                                if (rx_next == MATCH && pending_i) begin
                                    state <= RSP_ACK_DRV;
                                    tx_q  <= {dev_addr_i, 1'b0};
                                end else begin
                                    state <= RSP_IGNORE;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    RSP_ACK_DRV: begin
                        if (scl_fall) begin
                            oe_q  <= 1'b1;
                            state <= RSP_ACK_BIT;
                        end
                    end
                    RSP_ACK_BIT: begin
                        if (scl_rise) begin
                            state <= RSP_ACK_END;
                        end
                    end
                    RSP_ACK_END: begin
                        if (scl_fall) begin
                            oe_q  <= ~tx_msb;
                            state <= RSP_DATA;
                        end
                    end
                    RSP_DATA: begin
                        if (scl_rise) begin
                            if (tx_msb && !sda_s) begin
                                oe_q  <= 1'b0;
                                state <= RSP_IGNORE;
                            end else begin
                                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                                if (cnt_q == LAST_BIT) begin
                                    cnt_q <= '0;
                                    clr_q <= 1'b1;
                                    state <= RSP_MACK;
                                end else begin
                                    cnt_q <= cnt_q + 1'b1;
                                end
                            end
                        end else if (scl_fall) begin
                            oe_q <= ~tx_msb;
                        end
                    end
                    RSP_MACK: begin
                        if (scl_fall) begin
                            oe_q  <= 1'b0;
                            state <= RSP_IGNORE;
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Drive the outputs from registers only.
    always_comb begin
        sda_oe_o = oe_q;
        clear_o  = clr_q;
    end

endmodule

// File: rtl/smb_alert_responder.sv
// Module: top of the alert response responder.
// Synchronises the bus lines, detects START/STOP and runs the transaction
// engine that answers the alert response address with the device address.
// Assumes: the pad pulls SDA low while sda_oe_o is high; SCL is never driven.
module smb_alert_responder #(
    parameter int                ADDR_W      = 7,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] ARA_ADDR    = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              alert_pending_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic              alert_clear_o
);

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;

    logic [1:0] line_s;
    logic [1:0] line_rise;
    logic [1:0] line_fall;
    logic       start_cond;
    logic       stop_cond;
    logic       scl_sync;
    logic       bus_abort;

    smb_ara_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_i, scl_i}),
        .sync_o  (line_s),
        .rise_o  (line_rise),
        .fall_o  (line_fall)
    );

    smb_ara_cond i_cond (
        .scl_s    (line_s[LN_SCL]),
        .sda_rise (line_rise[LN_SDA]),
        .sda_fall (line_fall[LN_SDA]),
        .start_o  (start_cond),
        .stop_o   (stop_cond)
    );

    smb_ara_fsm #(
        .ADDR_W   (ADDR_W),
        .ARA_ADDR (ARA_ADDR)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (line_rise[LN_SCL]),
        .scl_fall   (line_fall[LN_SCL]),
        .sda_s      (line_s[LN_SDA]),
        .start_i    (start_cond),
        .stop_i     (stop_cond),
        .pending_i  (alert_pending_i),
        .dev_addr_i (dev_addr_i),
        .sda_oe_o   (sda_oe_o),
        .clear_o    (alert_clear_o)
    );

    // Observation taps for the bound checker.
    always_comb begin
        scl_sync  = line_s[LN_SCL];
        bus_abort = start_cond | stop_cond;
    end

endmodule

// File: rtl/smb_ara_chk.sv
// Module: protocol checker for the alert response responder, bound to the top.
// Assumes: signals are sampled on the system clock; reset is active low.
module smb_ara_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic clr,
    input logic scl_s,
    input logic bus_abort
);

    // R5
    clear_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);

    // R3
    clear_during_low_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> sda_oe);

    // R7
    drive_starts_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R6
    abort_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |=> !sda_oe);

endmodule

bind smb_alert_responder smb_ara_chk i_ara_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .clr       (alert_clear_o),
    .scl_s     (scl_sync),
    .bus_abort (bus_abort)
);

// File: tb/test_smb_alert_responder.sv
module test_smb_alert_responder;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       p_low = 1'b0;
    logic       pending = 1'b0;
    logic [6:0] dev_addr = 7'h00;
    logic       sda_oe;
    logic       clr;
    logic       sda_line;

    int checks = 0;
    int fails = 0;
    int clr_cnt = 0;
    logic       p_on = 1'b0;
    logic [7:0] p_byte = 8'h00;

    always #2 clk = ~clk;

    assign sda_line = ~(m_low | p_low | sda_oe);

    smb_alert_responder i_smb_alert_responder (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl),
        .sda_i           (sda_line),
        .sda_oe_o        (sda_oe),
        .alert_pending_i (pending),
        .dev_addr_i      (dev_addr),
        .alert_clear_o   (clr)
    );

    always @(posedge clk) if (rst_n && clr) clr_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        m_low = 1'b0; idle(Q);
        scl = 1'b1;   idle(Q);
        m_low = 1'b1; idle(Q);
        scl = 1'b0;   idle(Q);
    endtask

    task automatic stop_c();
        m_low = 1'b1; idle(Q);
        scl = 1'b1;   idle(Q);
        m_low = 1'b0; idle(Q);
    endtask

    task automatic bit_io(input logic b, output logic s);
        m_low = ~b; idle(Q);
        scl = 1'b1; idle(Q);
        s = sda_line; idle(Q);
        scl = 1'b0; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            p_low = p_on & ~p_byte[i];
            bit_io(1'b1, s);
            d[i] = s;
            if (p_on && p_byte[i] && !s) p_on = 1'b0;
        end
        p_low = 1'b0;
        p_on = 1'b0;
        bit_io(~mack, s);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R6", "reset sda_oe", int'(sda_oe), 0);
        chk(clr == 1'b0, "R6", "reset clear", int'(clr), 0);
    endtask

    task automatic t_basic();
        logic ack; logic [7:0] d; int c0;
        dev_addr = 7'h4B; pending = 1'b1; c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack); recv_byte(1'b0, d); stop_c();
        chk(ack == 1'b0, "R1", "ARA read ack", int'(ack), 0);
        chk(d == 8'h96, "R3", "returned byte", int'(d), 8'h96);
        chk(clr_cnt - c0 == 1, "R5", "clear pulses", clr_cnt - c0, 1);
    endtask

    task automatic t_no_pending();
        logic ack; logic [7:0] d; int c0;
        dev_addr = 7'h4B; pending = 1'b0; c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack); recv_byte(1'b0, d); stop_c();
        chk(ack == 1'b1, "R2", "no-pending ack", int'(ack), 1);
        chk(d == 8'hFF, "R2", "no-pending byte", int'(d), 8'hFF);
        chk(clr_cnt == c0, "R2", "no-pending clears", clr_cnt - c0, 0);
    endtask

    task automatic t_wrong_addr();
        logic ack; logic [7:0] d; int c0;
        dev_addr = 7'h4B; pending = 1'b1; c0 = clr_cnt;
        start_c(); send_byte(8'h91, ack); recv_byte(1'b0, d); stop_c();
        chk(ack == 1'b1, "R1", "other addr ack", int'(ack), 1);
        chk(d == 8'hFF, "R1", "other addr byte", int'(d), 8'hFF);
        start_c(); send_byte(8'h18, ack); stop_c();
        chk(ack == 1'b1, "R1", "ARA write ack", int'(ack), 1);
        chk(clr_cnt == c0, "R1", "wrong addr clears", clr_cnt - c0, 0);
    endtask

    task automatic t_arb_lose();
        logic ack; logic [7:0] d; int c0;
        dev_addr = 7'h2A; pending = 1'b1; c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack);
        p_on = 1'b1; p_byte = 8'h40;
        recv_byte(1'b0, d);
        chk(sda_oe == 1'b0, "R4", "released after loss", int'(sda_oe), 0);
        stop_c();
        chk(d == 8'h40, "R4", "lower peer wins", int'(d), 8'h40);
        chk(clr_cnt == c0, "R4", "loser clears", clr_cnt - c0, 0);
    endtask

    task automatic t_arb_win();
        logic ack; logic [7:0] d; int c0;
        dev_addr = 7'h11; pending = 1'b1; c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack);
        p_on = 1'b1; p_byte = 8'h78;
        recv_byte(1'b0, d); stop_c();
        chk(d == 8'h22, "R4", "lower own addr wins", int'(d), 8'h22);
        chk(clr_cnt - c0 == 1, "R5", "winner clears", clr_cnt - c0, 1);
    endtask

    task automatic t_abort();
        logic ack; logic s; logic [7:0] d; int c0;
        dev_addr = 7'h7F; pending = 1'b1; c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack);
        for (int i = 0; i < 3; i++) bit_io(1'b1, s);
        start_c();
        chk(sda_oe == 1'b0, "R6", "released at repeated START", int'(sda_oe), 0);
        send_byte(8'h19, ack);
        chk(ack == 1'b0, "R6", "new address after START", int'(ack), 0);
        recv_byte(1'b0, d); stop_c();
        chk(d == 8'hFE, "R6", "byte after restart", int'(d), 8'hFE);
        chk(clr_cnt - c0 == 1, "R6", "single clear after abort", clr_cnt - c0, 1);
        c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack);
        for (int i = 0; i < 2; i++) bit_io(1'b1, s);
        stop_c();
        chk(sda_oe == 1'b0, "R6", "released at STOP", int'(sda_oe), 0);
        chk(clr_cnt == c0, "R6", "no clear after STOP abort", clr_cnt - c0, 0);
    endtask

    task automatic t_latency();
        logic s; logic [7:0] d;
        dev_addr = 7'h4B; pending = 1'b1;
        start_c();
        for (int i = 7; i >= 1; i--) bit_io(((8'h19 >> i) & 1) != 0, s);
        m_low = 1'b0; idle(Q);
        scl = 1'b1; idle(2 * Q);
        scl = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk(sda_oe == 1'b0, "R7", "oe before 3rd edge", int'(sda_oe), 0);
        @(posedge clk); #1;
        chk(sda_oe == 1'b1, "R7", "oe at 3rd edge", int'(sda_oe), 1);
        idle(Q);
        bit_io(1'b1, s);
        chk(s == 1'b0, "R7", "ack on line", int'(s), 0);
        recv_byte(1'b0, d); stop_c();
    endtask

    task automatic t_master_ack();
        logic ack; logic [7:0] d; int c0;
        dev_addr = 7'h33; pending = 1'b1; c0 = clr_cnt;
        start_c(); send_byte(8'h19, ack); recv_byte(1'b1, d);
        chk(sda_oe == 1'b0, "R8", "released after master ACK", int'(sda_oe), 0);
        chk(d == 8'h66, "R8", "byte with master ACK", int'(d), 8'h66);
        stop_c();
        chk(clr_cnt - c0 == 1, "R8", "clears with master ACK", clr_cnt - c0, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        idle(5);
        t_reset();
        rst_n = 1'b1;
        idle(5);
        t_basic();
        t_no_pending();
        t_wrong_addr();
        t_arb_lose();
        t_arb_win();
        t_abort();
        t_latency();
        t_master_ack();
        idle(10);
        finish_run();
    end

endmodule